// File: doc/BRIEF.md
# I2C Bit Timer with Programmable SDA Hold

This block is the bit-level timing engine of an I2C master. It runs from a 27.12 MHz system clock. Each accepted command takes up one SCL slot. A slot lasts `baud_i + 27` system cycles, so a baud setting of 0 gives about 1 MHz, 0x29 gives about 400 kHz and 0x35 gives about 339 kHz.

The block drives open-drain SCL and SDA through active-high pull-down enables. A 1 on `scl_oe_o` or `sda_oe_o` pulls the line low. After each SCL falling edge, outgoing data is placed on SDA a programmable number of cycles later. This meets the 300 ns hold minimum of standard and fast modes. In fast-mode plus the data moves with the falling edge itself.

A controller feeds commands through a valid/ready handshake. The command kinds are data bit, START and STOP. Commands presented back to back give a continuous SCL. A received bit is sampled once per data slot, at the middle of the SCL high phase. Byte framing, addressing, clock stretching and arbitration belong to the controller above.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and right after it, `scl_oe_o` and `sda_oe_o` are 0 (both lines released), `cmd_ready_o` is 1 and `rx_valid_o` is 0.
- R2: A data slot lasts exactly `baud_i + 27` cycles. SCL is pulled low for the first ceil(P/2) cycles and released for the remaining floor(P/2) cycles, where P is the slot length.
- R3: `baud_i` is captured only when a command is accepted. A change during a slot leaves that slot's length unchanged and applies from the next slot.
- R4: In standard/fast mode (`fm_plus_i` = 0) with a nonzero hold, `sda_oe_o` takes the new bit value in slot cycle number `hold_i`. Cycle 0 is the first cycle with SCL low.
- R5: In standard/fast mode, `hold_i` = 0 selects a built-in hold of 9 cycles (at least 300 ns at 27.12 MHz).
- R6: With `fm_plus_i` = 1, `hold_i` has no effect and SDA takes its new value in slot cycle 0.
- R7: An effective hold larger than ceil(P/2) − 1 is clamped to ceil(P/2) − 1, so data settles before SCL is released.
- R8: A START slot (`cmd_i` = 2'b01) keeps SCL released for the whole slot. It keeps the previous SDA level for ceil(P/2) cycles and then pulls SDA low.
- R9: A STOP slot (`cmd_i` = 2'b10) pulls SCL low for ceil(P/2) cycles and pulls SDA low from the hold cycle on. At the end of the slot it releases SDA with SCL released, and both lines stay released while idle.
- R10: `cmd_ready_o` is 1 when idle and in the last cycle of a slot. A command accepted on a clock edge starts its slot in the next cycle. With no command pending, the block idles with SCL released.
- R11: In a data slot (`cmd_i` = 2'b00; 2'b11 also acts as data), `sda_i` is sampled in cycle ceil(P/2) + floor(floor(P/2)/2). The value appears on `rx_bit_o` with a one-cycle `rx_valid_o` pulse in the following cycle.
- R12: Inside a data slot, SDA never changes while SCL is released. A data slot drives `sda_oe_o` = NOT `tx_bit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27.12 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_i | input | BAUD_W | SCL period setting; the period is this value plus 27 |
| hold_i | input | HOLD_W | SDA hold in cycles after SCL falls; 0 selects the built-in value |
| fm_plus_i | input | 1 | 1 selects fast-mode plus (zero hold) |
| cmd_valid_i | input | 1 | A command is presented |
| cmd_i | input | 2 | 00 data, 01 START, 10 STOP, 11 data |
| tx_bit_i | input | 1 | Bit to send in a data slot |
| cmd_ready_o | output | 1 | The command is taken on this edge if valid |
| sda_i | input | 1 | Sensed SDA line level |
| rx_bit_o | output | 1 | Last sampled receive bit |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_bit_o` is updated |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Several properties are checked on every cycle:
- SDA stays stable while SCL is released inside a data slot.
- SCL stays released through a START slot.
- SCL falls only in the first cycle of a slot.
- A slot never ends before its last cycle.
- Both lines are released once a STOP completes.
- The receive strobe lasts one cycle.

Other behaviours only the bench scenarios can show. These are the exact low and high phase lengths for each baud value, the cycle in which SDA changes for each hold, default and fast-mode-plus setting, the clamp of an oversized hold, the sampling cycle, and that a baud change mid-slot only affects the next slot.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  typedef enum logic [1:0] {
    CMD_DATA  = 2'b00,
    CMD_START = 2'b01,
    CMD_STOP  = 2'b10,
    CMD_ALT   = 2'b11
  } cmd_e;

  localparam int unsigned PERIOD_BASE  = 27;
  localparam int unsigned HOLD_DEFAULT = 9;
endpackage

// File: rtl/i2c_bt_period.sv
module i2c_bt_period #(
  parameter  int unsigned BAUD_W = 8,
  parameter  int unsigned BASE   = 27,
  localparam int unsigned CNT_W  = BAUD_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic [CNT_W-1:0] lo_len_o,
  output logic [CNT_W-1:0] sample_pt_o,
  output logic [CNT_W-1:0] lo_next_o
);
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE);

  logic [CNT_W-1:0] period_q, cnt_q, next_period, hi_len;

  assign next_period = CNT_W'(baud_i) + BASE_C;
  // ceil(p/2) without overflow
  assign lo_next_o   = (next_period >> 1) + CNT_W'(next_period[0]);
  assign lo_len_o    = (period_q >> 1) + CNT_W'(period_q[0]);
  assign hi_len      = period_q >> 1;
  assign sample_pt_o = lo_len_o + (hi_len >> 1);
  assign last_o      = run_i && (cnt_q == period_q - 1'b1);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= BASE_C;
    end else if (load_i) begin
      cnt_q    <= '0;
      period_q <= next_period;
    end else if (run_i && !last_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bt_hold.sv
module i2c_bt_hold #(
  parameter int unsigned HOLD_W   = 5,
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned DEF_HOLD = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              fmp_i,
  input  logic [CNT_W-1:0]  lo_next_i,
  output logic [CNT_W-1:0]  hold_o
);
  logic [CNT_W-1:0] raw, lim, eff, hold_q;

  always_comb begin
    if (fmp_i)             raw = '0;
    else if (hold_i == '0) raw = CNT_W'(DEF_HOLD);
    else                   raw = CNT_W'(hold_i);
    lim = lo_next_i - 1'b1;
    eff = (raw > lim) ? lim : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= eff;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/i2c_bt_rx.sv
module i2c_bt_rx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic sda_i,
  output logic rx_bit_o,
  output logic rx_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_bit_o   <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= sample_i;
      if (sample_i) rx_bit_o <= sda_i;
    end
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter  int unsigned BAUD_W   = 8,
  parameter  int unsigned HOLD_W   = 5,
  parameter  int unsigned BASE     = i2c_bt_pkg::PERIOD_BASE,
  parameter  int unsigned DEF_HOLD = i2c_bt_pkg::HOLD_DEFAULT,
  localparam int unsigned CNT_W    = BAUD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              fm_plus_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              tx_bit_i,
  output logic              cmd_ready_o,
  input  logic              sda_i,
  output logic              rx_bit_o,
  output logic              rx_valid_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  import i2c_bt_pkg::*;

  logic             active_q, new_low_q, held_q;
  cmd_e             kind_q, kind_in;
  logic             accept, last;
  logic [CNT_W-1:0] cnt, lo_len, sample_pt, lo_next, hold_cyc, chg_pt;

  assign kind_in     = (cmd_e'(cmd_i) == CMD_ALT) ? CMD_DATA : cmd_e'(cmd_i);
  assign cmd_ready_o = !active_q || last;
  assign accept      = cmd_valid_i && cmd_ready_o;

  i2c_bt_period #(.BAUD_W(BAUD_W), .BASE(BASE)) u_period (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .run_i       (active_q),
    .baud_i      (baud_i),
    .cnt_o       (cnt),
    .last_o      (last),
    .lo_len_o    (lo_len),
    .sample_pt_o (sample_pt),
    .lo_next_o   (lo_next)
  );

  i2c_bt_hold #(.HOLD_W(HOLD_W), .CNT_W(CNT_W), .DEF_HOLD(DEF_HOLD)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .hold_i    (hold_i),
    .fmp_i     (fm_plus_i),
    .lo_next_i (lo_next),
    .hold_o    (hold_cyc)
  );

  i2c_bt_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (active_q && kind_q == CMD_DATA && cnt == sample_pt),
    .sda_i      (sda_i),
    .rx_bit_o   (rx_bit_o),
    .rx_valid_o (rx_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      kind_q    <= CMD_DATA;
      new_low_q <= 1'b0;
      held_q    <= 1'b0;
    end else begin
      if (last) held_q <= (kind_q == CMD_STOP) ? 1'b0 : new_low_q;
      if (accept) begin
        active_q  <= 1'b1;
        kind_q    <= kind_in;
        new_low_q <= (kind_in == CMD_DATA) ? !tx_bit_i : 1'b1;
      end else if (last) begin
        active_q <= 1'b0;
      end
    end
  end

  // START moves SDA at mid-slot with SCL high; others after the hold
  assign chg_pt   = (kind_q == CMD_START) ? lo_len : hold_cyc;
  assign sda_oe_o = (active_q && cnt >= chg_pt) ? new_low_q : held_q;
  assign scl_oe_o = active_q && kind_q != CMD_START && cnt < lo_len;
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active_i,
  input logic [1:0]       kind_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cmd_ready_i,
  input logic             scl_oe_i,
  input logic             sda_oe_i,
  input logic             rx_valid_i
);
  import i2c_bt_pkg::*;

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && kind_i == CMD_DATA && cnt_i != '0 && !scl_oe_i && $past(!scl_oe_i)) |-> $stable(sda_oe_i)); // R12
  AST_START_SCL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && kind_i == CMD_START) |-> !scl_oe_i); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(active_i) && $past(kind_i) == CMD_STOP) |-> (!scl_oe_i && !sda_oe_i)); // R9
  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i); // R11
  AST_NO_EARLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !cmd_ready_i) |=> (active_i && cnt_i == $past(cnt_i) + 1'b1)); // R2
  AST_SCL_FALL_SLOT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_i) |-> (active_i && cnt_i == '0)); // R2
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> cmd_ready_i); // R10
endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active_i    (active_q),
  .kind_i      (kind_q),
  .cnt_i       (cnt),
  .cmd_ready_i (cmd_ready_o),
  .scl_oe_i    (scl_oe_o),
  .sda_oe_i    (sda_oe_o),
  .rx_valid_i  (rx_valid_o)
);

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] baud = '0;
  logic [4:0] hold = '0;
  logic       fmp = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       tx_bit = 1'b0;
  logic       sda_in = 1'b1;
  logic       cmd_ready_o, rx_bit_o, rx_valid_o, scl_oe_o, sda_oe_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int m_low, m_high, m_first, m_rx_n, m_rx_k, m_total;
  logic m_rx_bit;

  always #5 clk = ~clk;

  i2c_bit_timer u_i2c_bit_timer (
    .clk_i(clk), .rst_ni(rst_n), .baud_i(baud), .hold_i(hold), .fm_plus_i(fmp),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .tx_bit_i(tx_bit), .cmd_ready_o(cmd_ready_o),
    .sda_i(sda_in), .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  typedef struct packed {
    logic [7:0] baud;
    logic [4:0] hold;
    logic       fmp;
    logic [8:0] lo;
    logic [8:0] hi;
    logic [8:0] h;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   5'd0,  1'b0, 9'd14,  9'd13,  9'd9},
    '{8'd41,  5'd0,  1'b0, 9'd34,  9'd34,  9'd9},
    '{8'd53,  5'd12, 1'b0, 9'd40,  9'd40,  9'd12},
    '{8'd109, 5'd19, 1'b0, 9'd68,  9'd68,  9'd19},
    '{8'd53,  5'd15, 1'b1, 9'd40,  9'd40,  9'd0},
    '{8'd0,   5'd31, 1'b0, 9'd14,  9'd13,  9'd13},
    '{8'd54,  5'd9,  1'b0, 9'd41,  9'd40,  9'd9},
    '{8'd255, 5'd0,  1'b1, 9'd141, 9'd141, 9'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the slot's last cycle
  task automatic run_slot(input logic [1:0] c, input logic b, input logic sin,
                          input logic exp_new, input int chg_k, input logic [7:0] chg_b);
    cmd_valid = 1'b1; cmd = c; tx_bit = b; sda_in = sin;
    while (!cmd_ready_o) @(negedge clk);
    @(posedge clk);
    m_low = 0; m_high = 0; m_first = -1; m_rx_n = 0; m_rx_k = -1; m_total = 0; m_rx_bit = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      if (scl_oe_o) m_low++; else m_high++;
      if (m_first < 0 && sda_oe_o == exp_new) m_first = k;
      if (rx_valid_o) begin m_rx_n++; m_rx_k = k; m_rx_bit = rx_bit_o; end
      if (k == chg_k) baud = chg_b;
      if (cmd_ready_o) begin m_total = k + 1; break; end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    string htag;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1", "scl_oe in reset", int'(scl_oe_o), 0);
    chk("R1", "sda_oe in reset", int'(sda_oe_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(cmd_ready_o), 1);
    chk("R1", "rx_valid after reset", int'(rx_valid_o), 0);
    chk("R1", "scl_oe after reset", int'(scl_oe_o), 0);

    foreach (VECS[i]) begin
      baud = VECS[i].baud; hold = VECS[i].hold; fmp = VECS[i].fmp;
      if (VECS[i].fmp) htag = "R6";
      else if (VECS[i].hold == 0) htag = "R5";
      else if (int'(VECS[i].hold) > int'(VECS[i].lo) - 1) htag = "R7";
      else htag = "R4";
      run_slot(2'b01, 1'b0, 1'b1, 1'b1, -1, 8'd0);
      chk("R8", "start scl low cycles", m_low, 0);
      chk("R8", "start sda fall cycle", m_first, int'(VECS[i].lo));
      run_slot(2'b00, 1'b1, 1'b1, 1'b0, -1, 8'd0);
      chk("R2", "data1 low phase", m_low, int'(VECS[i].lo));
      chk("R2", "data1 high phase", m_high, int'(VECS[i].hi));
      chk("R2", "data1 period", m_total, int'(VECS[i].baud) + 27);
      chk(htag, "data1 sda change cycle", m_first, int'(VECS[i].h));
      chk("R11", "data1 rx pulses", m_rx_n, 1);
      chk("R11", "data1 rx cycle", m_rx_k, int'(VECS[i].lo) + int'(VECS[i].hi) / 2 + 1);
      chk("R11", "data1 rx bit", int'(m_rx_bit), 1);
      run_slot(2'b11, 1'b0, 1'b0, 1'b1, -1, 8'd0);
      chk(htag, "data0 sda change cycle", m_first, int'(VECS[i].h));
      chk("R11", "data0 rx bit", int'(m_rx_bit), 0);
      run_slot(2'b10, 1'b0, 1'b1, 1'b1, -1, 8'd0);
      chk("R9", "stop low phase", m_low, int'(VECS[i].lo));
      @(negedge clk);
      chk("R9", "scl released after stop", int'(scl_oe_o), 0);
      chk("R9", "sda released after stop", int'(sda_oe_o), 0);
    end

    // R3: baud change mid-slot applies from the next slot
    baud = 8'd0; hold = 5'd0; fmp = 1'b0;
    run_slot(2'b01, 1'b0, 1'b1, 1'b1, -1, 8'd0);
    run_slot(2'b00, 1'b1, 1'b1, 1'b0, 3, 8'd41);
    chk("R3", "slot with mid change", m_total, 27);
    run_slot(2'b00, 1'b0, 1'b0, 1'b1, -1, 8'd0);
    chk("R3", "slot after change", m_total, 68);
    chk("R12", "data0 sda low cycle", m_first, 9);
    run_slot(2'b10, 1'b0, 1'b1, 1'b1, -1, 8'd0);

    // R10: idle without command keeps lines released and ready high
    repeat (6) @(negedge clk);
    chk("R10", "idle ready", int'(cmd_ready_o), 1);
    chk("R10", "idle scl released", int'(scl_oe_o), 0);
    chk("R10", "idle sda released", int'(sda_oe_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule